// File: doc/BRIEF.md
# Expanded Memory Array with Chip-Select Decoding

This block assembles a 4K x 8 byte-wide memory from eight smaller 1K x 4 storage tiles. Two tiles sit side by side so that one holds the low nibble of each byte and the other holds the high nibble. Four such byte-wide pairs are stacked to give four 1K banks, so the address space grows from 1K to 4K. Every tile sees the same ten low address bits. The two high address bits only choose which bank answers.

A processor-side port drives a 12-bit address, a byte of write data, a single direction line and an active-low memory-request strobe. The direction line means read when it is high and write when it is low. When the strobe is high, the cycle belongs to another address space, so no bank is selected and nothing is stored. Read data is registered and is returned one clock after the read is presented. The output is zero in every cycle that does not follow a read.

Top module: `expandedMem`

## Requirements
- R1: While rstN is low, and in the first cycle after it, rdData is 0x00.
- R2: A write (memReqN=0, rdWr=0) stores wrData at addr on the rising edge. A read (memReqN=0, rdWr=1) of that address in the very next cycle returns the byte on rdData after that edge.
- R3: addr[11:10] selects one of four independent banks, and addr[9:0] selects the word inside the bank. Bytes written at the same addr[9:0] in different banks do not disturb each other.
- R4: At most one bank chip select is active in any cycle, and the active one is the bank named by addr[11:10].
- R5: With memReqN=1, no bank is selected and no location changes, whatever rdWr, addr and wrData are. rdData is 0x00 after such a cycle.
- R6: Bits [3:0] and bits [7:4] of each byte are held in separate tiles, and both are written by every write. Bytes whose two nibbles differ read back with each nibble in its own position.
- R7: After any cycle that is not a read (a write, or an idle cycle), rdData is 0x00.
- R8: A write changes only the addressed byte. Neighbouring addresses keep their contents.
- R9: Reads issued in consecutive cycles return their bytes in consecutive cycles, in issue order, each one cycle after its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every store and every read capture happens on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the read register |
| addr | input | 12 | Byte address; [11:10] is the bank, [9:0] is the word in the bank |
| wrData | input | 8 | Byte to store during a write |
| rdWr | input | 1 | Direction: 1 = read, 0 = write |
| memReqN | input | 1 | Active-low memory request; high blocks every bank |
| rdData | output | 8 | Registered read byte, zero when the previous cycle was not a read |

## Verification
The bench writes bytes at the same in-bank offset in all four banks and reads each one back. A decoder that ignored or swapped the high address bits would return the wrong bank's byte. It also attempts writes with the request strobe high and then reads the target back. Gating that leaked past the strobe would show up as an overwritten byte or a non-zero output. Bytes with unequal nibbles, and writes to the neighbours of a known location, would expose swapped tile lanes or an offset decode that was too wide. Back-to-back reads and reads that follow a write or an idle cycle catch an extra or missing stage in the output register and an output that fails to clear.

// File: rtl/expandedMemPkg.sv
package expandedMemPkg;

  // Strobes passed from the request decoder to the storage datapath.
  typedef struct packed {
    logic wrEn;   // store cycle for the selected bank
    logic rdEn;   // read cycle for the selected bank
  } memStrobe_t;

endpackage

// File: rtl/memCtrl.sv
module memCtrl
  import expandedMemPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SUB_AW = 10,
  localparam int BANK_W = ADDR_W - SUB_AW,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rdWr,
  input  logic                 memReqN,
  output memStrobe_t           strobe,
  output logic [NUM_BANKS-1:0] chipSel
);

  logic              reqActive;
  logic [BANK_W-1:0] bankIdx;

  assign reqActive   = ~memReqN;
  assign bankIdx     = addr[ADDR_W-1:SUB_AW];
  assign strobe.wrEn = reqActive & ~rdWr;
  assign strobe.rdEn = reqActive & rdWr;

  // One-hot bank decoder, qualified by the memory request.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign chipSel[b] = reqActive && (bankIdx == BANK_W'(b));
  end

endmodule

// File: rtl/memSubArray.sv
module memSubArray #(
  parameter int AW = 10,
  parameter int DW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sel,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (sel && wrEn) cells[addr] <= wrData;
  end

  // The output register drives zero unless this tile is read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (sel && rdEn)  rdData <= cells[addr];
    else                   rdData <= '0;
  end

endmodule

// File: rtl/memDatapath.sv
module memDatapath
  import expandedMemPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SUB_AW = 10,
  parameter int DATA_W = 8,
  parameter int SUB_DW = 4,
  localparam int BANK_W = ADDR_W - SUB_AW,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int SLICES = DATA_W / SUB_DW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  memStrobe_t           strobe,
  input  logic [NUM_BANKS-1:0] chipSel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData
);

  logic [DATA_W-1:0] bankData [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
      memSubArray #(.AW(SUB_AW), .DW(SUB_DW)) u_tile (
        .clk    (clk),
        .rstN   (rstN),
        .sel    (chipSel[b]),
        .wrEn   (strobe.wrEn),
        .rdEn   (strobe.rdEn),
        .addr   (addr[SUB_AW-1:0]),
        .wrData (wrData[s*SUB_DW +: SUB_DW]),
        .rdData (bankData[b][s*SUB_DW +: SUB_DW])
      );
    end
  end

  // Unselected banks output zero, so an OR merges the shared bus.
  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdData = rdData | bankData[b];
  end

endmodule

// File: rtl/expandedMem.sv
module expandedMem
  import expandedMemPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SUB_AW = 10,
  parameter int DATA_W = 8,
  parameter int SUB_DW = 4,
  localparam int NUM_BANKS = 1 << (ADDR_W - SUB_AW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdWr,
  input  logic              memReqN,
  output logic [DATA_W-1:0] rdData
);

  memStrobe_t           strobe;
  logic [NUM_BANKS-1:0] chipSel;

  memCtrl #(.ADDR_W(ADDR_W), .SUB_AW(SUB_AW)) u_ctrl (
    .addr    (addr),
    .rdWr    (rdWr),
    .memReqN (memReqN),
    .strobe  (strobe),
    .chipSel (chipSel)
  );

  memDatapath #(
    .ADDR_W(ADDR_W), .SUB_AW(SUB_AW), .DATA_W(DATA_W), .SUB_DW(SUB_DW)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .chipSel (chipSel),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: rtl/expandedMemChecker.sv
module expandedMemChecker #(
  parameter int ADDR_W = 12,
  parameter int SUB_AW = 10,
  parameter int DATA_W = 8,
  localparam int NUM_BANKS = 1 << (ADDR_W - SUB_AW)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic                 rdWr,
  input logic                 memReqN,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_BANKS-1:0] chipSel
);

  // R4: never two banks at once
  a_r4_single_bank: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel));

  // R4: the active select follows the high address bits
  a_r4_bank_matches_addr: assert property (@(posedge clk) disable iff (!rstN)
    !memReqN |-> chipSel[addr[ADDR_W-1:SUB_AW]]);

  // R5: a high request strobe blocks every bank
  a_r5_no_select_idle: assert property (@(posedge clk) disable iff (!rstN)
    memReqN |-> (chipSel == '0));

  // R5: output is zero after a blocked cycle
  a_r5_idle_output_zero: assert property (@(posedge clk) disable iff (!rstN)
    memReqN |=> (rdData == '0));

  // R7: output is zero after a write cycle
  a_r7_write_output_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && !rdWr) |=> (rdData == '0));

  // R2: a read right after a write to the same address returns the byte
  a_r2_read_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && !rdWr) ##1 (!memReqN && rdWr && addr == $past(addr))
      |=> (rdData == $past(wrData, 2)));

endmodule

bind expandedMem expandedMemChecker #(
  .ADDR_W(ADDR_W), .SUB_AW(SUB_AW), .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrData  (wrData),
  .rdWr    (rdWr),
  .memReqN (memReqN),
  .rdData  (rdData),
  .chipSel (chipSel)
);

// File: tb/expandedMem_bench.sv
module expandedMem_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // Each entry: {address[19:8], byte[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {12'h000, 8'h1E}, {12'h400, 8'h2D}, {12'h800, 8'h3C}, {12'hC00, 8'h4B},
    {12'h3FF, 8'hA5}, {12'hFFF, 8'h5A}, {12'h155, 8'hF0}, {12'hAAA, 8'h0F}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        rdWr = 1'b1;
  logic        memReqN = 1'b1;
  logic [7:0]  rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  expandedMem u_expandedMem (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .rdWr(rdWr), .memReqN(memReqN), .rdData(rdData)
  );

  // Apply one cycle of inputs; return 1 time unit after the capturing edge.
  task automatic cyc(input logic [11:0] a, input logic rw,
                     input logic reqN, input logic [7:0] d);
    addr = a; rdWr = rw; memReqN = reqN; wrData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s rdData=%02h expected=%02h", req, rdData, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", 8'h00);
    rstN = 1'b1;
    cyc(12'h000, 1'b1, 1'b1, 8'h00);
    check("R1", 8'h00);

    // R3 R6: fill all banks from the table, then read back
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][19:8], 1'b0, 1'b0, VEC[i][7:0]);
      check("R7", 8'h00);
    end
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][19:8], 1'b1, 1'b0, 8'h00);
      check("R3_R6", VEC[i][7:0]);
    end

    // R5: writes with the strobe high must not store
    cyc(12'h400, 1'b0, 1'b1, 8'hEE);
    check("R5", 8'h00);
    cyc(12'hC00, 1'b0, 1'b1, 8'h77);
    cyc(12'h400, 1'b1, 1'b0, 8'h00);
    check("R5", 8'h2D);
    cyc(12'hC00, 1'b1, 1'b0, 8'h00);
    check("R5", 8'h4B);
    // R5: read with strobe high gives zero
    cyc(12'hC00, 1'b1, 1'b1, 8'h00);
    check("R5", 8'h00);

    // R2: write then immediate read
    cyc(12'h801, 1'b0, 1'b0, 8'h96);
    cyc(12'h801, 1'b1, 1'b0, 8'h00);
    check("R2", 8'h96);

    // R8: neighbours of 0x155 written; 0x155 unchanged
    cyc(12'h154, 1'b0, 1'b0, 8'h11);
    cyc(12'h156, 1'b0, 1'b0, 8'h22);
    cyc(12'h555, 1'b0, 1'b0, 8'h33);
    cyc(12'h155, 1'b1, 1'b0, 8'h00);
    check("R8", 8'hF0);
    cyc(12'h154, 1'b1, 1'b0, 8'h00);
    check("R8", 8'h11);

    // R7: idle cycle after a read clears the output
    cyc(12'h154, 1'b1, 1'b1, 8'h00);
    check("R7", 8'h00);

    // R9: back-to-back reads across banks
    cyc(12'h000, 1'b1, 1'b0, 8'h00);
    check("R9", 8'h1E);
    cyc(12'hFFF, 1'b1, 1'b0, 8'h00);
    check("R9", 8'h5A);
    cyc(12'h555, 1'b1, 1'b0, 8'h00);
    check("R9", 8'h33);
    cyc(12'h3FF, 1'b1, 1'b0, 8'h00);
    check("R9", 8'hA5);

    // R1: reset again mid-stream clears the output
    cyc(12'hAAA, 1'b1, 1'b0, 8'h00);
    check("R3", 8'h0F);
    rstN = 1'b0;
    #1;
    check("R1", 8'h00);
    rstN = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule